// File: doc/BRIEF.md
# Multi-Bank DRAM Command Sequencer

This block sits between a memory client and a simplified DRAM command bus. It takes read and write requests over a valid/ready handshake. Each request carries a bank, a row, a column, a burst flag and a tag. The block turns each request into the commands the DRAM needs: an open-row command, a column read or write, and a close-row command when a different row must be reached. It drives at most one command per clock.

Each bank keeps track of whether it has an open row, and which row that is. Rows stay open after a column access, so later accesses to the same row need only a column command. Each bank has a one-entry request slot and its own phase timer, so several banks can be working at the same time. Up to four transactions may be outstanding across all banks. A transaction completes a fixed latency after its column command, and the completion carries the request's tag.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, `cmdValid` and `doneValid` are low, and `reqReady` is high for every bank.
- R2: A request to a bank with no open row produces an ACT (`cmdKind`=1) one cycle after acceptance. Its column command follows exactly T_RCD cycles after that ACT.
- R3: A request to the row that is already open in a bank produces only its column command, one cycle after acceptance, with no ACT and no PRE.
- R4: A request to a bank whose open row differs from the request's row produces a PRE (`cmdKind`=0) one cycle after acceptance. An ACT follows T_RP cycles after the PRE, and the column command follows T_RCD cycles after the ACT.
- R5: A column command is a read (`cmdKind`=2) or a write (`cmdKind`=3). It carries the request's row. For a burst request, its column has the low three bits cleared (burst of 8) and `cmdBurst` is high. For a single-word request, the column passes unchanged and `cmdBurst` is low.
- R6: `doneValid` pulses exactly T_CL cycles after each column command. `doneTag` and `doneWrite` are those of that request.
- R7: When four accepted transactions have not yet completed, `reqReady` is low. It rises in the cycle after the completion pulse is seen.
- R8: `reqReady` is low while the addressed bank still holds a request whose column command has not been issued.
- R9: When more than one bank has a command due in the same cycle, the lowest-numbered bank is served. The others wait, and one command is driven per cycle.
- R10: Transactions to different banks overlap: one bank may be activated between another bank's ACT and that bank's column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | 1 = burst of 8 words |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| reqTag | input | TAG_W | Request identifier |
| cmdValid | output | 1 | Command on the bus this cycle |
| cmdKind | output | 2 | 0 PRE, 1 ACT, 2 RD, 3 WR |
| cmdBank | output | BANK_W | Command bank |
| cmdRow | output | ROW_W | Row of the bank's pending request |
| cmdCol | output | COL_W | Column, aligned for bursts |
| cmdBurst | output | 1 | Column command is a burst |
| doneValid | output | 1 | Completion pulse |
| doneTag | output | TAG_W | Tag of the completed request |
| doneWrite | output | 1 | Completed request was a write |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a new request being accepted and an older transaction completing. This is provoked by filling all four outstanding slots and then streaming requests to fresh banks as soon as `reqReady` returns, so that accepts land on completion edges. A bench-side count of accepts minus completions judges `reqReady` in every cycle.

The second pair is one bank's column command becoming due in the same cycle as another bank's ACT or PRE. This is provoked by placing a row hit on a low bank right behind a row miss on a higher bank. The outcome is judged against the exact issue cycles that follow from T_RP, T_RCD and fixed priority.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmdKind_t;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic accept;
    logic issueAct;
    logic issuePre;
    logic issueCol;
  } seqStrobe_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int MAX_OUT   = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] slotBusy,
  input  logic [NUM_BANKS-1:0] wantAct,
  input  logic [NUM_BANKS-1:0] wantPre,
  input  logic [NUM_BANKS-1:0] wantCol,
  input  logic                 doneValid,
  output logic                 reqReady,
  output seqStrobe_t           strobe,
  output logic [BANK_W-1:0]    grantBank
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] outCount;
  logic             found;
  logic [BANK_W-1:0] pick;

  assign reqReady = (outCount < CNT_MAX) && !slotBusy[reqBank];

  // Fixed priority: scan from the top so the lowest ready bank is kept
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (wantAct[b] || wantPre[b] || wantCol[b]) begin
        found = 1'b1;
        pick  = BANK_W'(b);
      end
    end
  end

  always_comb begin
    strobe.accept   = reqValid && reqReady;
    strobe.issueAct = found && wantAct[pick];
    strobe.issuePre = found && wantPre[pick];
    strobe.issueCol = found && wantCol[pick];
    grantBank       = pick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCount <= '0;
    end else begin
      outCount <= outCount + CNT_W'(strobe.accept) - CNT_W'(doneValid);
    end
  end

  // R7
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    outCount <= CNT_MAX);

  // R7
  accept_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !doneValid) |=> outCount == $past(outCount) + CNT_W'(1));

  // R6
  done_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> outCount != '0);

endmodule

// File: rtl/dram_seq_datapath.sv
module dram_seq_datapath
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TAG_W     = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_CL      = 3,
  parameter int BURST_LEN = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [BANK_W-1:0]    grantBank,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [COL_W-1:0]     reqCol,
  input  logic [TAG_W-1:0]     reqTag,
  output logic [NUM_BANKS-1:0] slotBusy,
  output logic [NUM_BANKS-1:0] wantAct,
  output logic [NUM_BANKS-1:0] wantPre,
  output logic [NUM_BANKS-1:0] wantCol,
  output logic                 cmdValid,
  output logic [1:0]           cmdKind,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [ROW_W-1:0]     cmdRow,
  output logic [COL_W-1:0]     cmdCol,
  output logic                 cmdBurst,
  output logic                 doneValid,
  output logic [TAG_W-1:0]     doneTag,
  output logic                 doneWrite
);

  localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TIM_W = $clog2(TMAX + 1);
  localparam logic [TIM_W-1:0] RCD_LOAD = TIM_W'(T_RCD - 1);
  localparam logic [TIM_W-1:0] RP_LOAD  = TIM_W'(T_RP - 1);
  localparam logic [COL_W-1:0] BURST_MASK = ~COL_W'(BURST_LEN - 1);

  // Per-bank request slot and open-row state
  logic             slotValid [NUM_BANKS];
  logic             slotWrite [NUM_BANKS];
  logic             slotBurst [NUM_BANKS];
  logic [ROW_W-1:0] slotRow   [NUM_BANKS];
  logic [COL_W-1:0] slotCol   [NUM_BANKS];
  logic [TAG_W-1:0] slotTag   [NUM_BANKS];
  logic             openValid [NUM_BANKS];
  logic [ROW_W-1:0] openRow   [NUM_BANKS];
  logic [TIM_W-1:0] timer     [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic idle;
    logic mine;
    assign idle       = slotValid[b] && (timer[b] == '0);
    assign mine       = (grantBank == BANK_W'(b));
    assign slotBusy[b] = slotValid[b];
    assign wantAct[b] = idle && !openValid[b];
    assign wantPre[b] = idle && openValid[b] && (openRow[b] != slotRow[b]);
    assign wantCol[b] = idle && openValid[b] && (openRow[b] == slotRow[b]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[b] <= 1'b0;
        slotWrite[b] <= 1'b0;
        slotBurst[b] <= 1'b0;
        slotRow[b]   <= '0;
        slotCol[b]   <= '0;
        slotTag[b]   <= '0;
        openValid[b] <= 1'b0;
        openRow[b]   <= '0;
        timer[b]     <= '0;
      end else begin
        if (strobe.accept && reqBank == BANK_W'(b)) begin
          slotValid[b] <= 1'b1;
          slotWrite[b] <= reqWrite;
          slotBurst[b] <= reqBurst;
          slotRow[b]   <= reqRow;
          slotCol[b]   <= reqCol;
          slotTag[b]   <= reqTag;
        end
        if (timer[b] != '0) timer[b] <= timer[b] - TIM_W'(1);
        if (mine && strobe.issueAct) begin
          openValid[b] <= 1'b1;
          openRow[b]   <= slotRow[b];
          timer[b]     <= RCD_LOAD;
        end
        if (mine && strobe.issuePre) begin
          openValid[b] <= 1'b0;
          timer[b]     <= RP_LOAD;
        end
        if (mine && strobe.issueCol) slotValid[b] <= 1'b0;
      end
    end

    // R4
    pre_open_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mine && strobe.issuePre) |-> openValid[b]);

    // R2
    act_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
      (mine && strobe.issueAct) |-> !openValid[b]);
  end

  // Command bus register
  cmdKind_t         cmdKindR;
  logic [TAG_W-1:0] cmdTagR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKindR <= CMD_PRE;
      cmdBank  <= '0;
      cmdRow   <= '0;
      cmdCol   <= '0;
      cmdBurst <= 1'b0;
      cmdTagR  <= '0;
    end else begin
      cmdValid <= strobe.issueAct || strobe.issuePre || strobe.issueCol;
      cmdBank  <= grantBank;
      cmdRow   <= slotRow[grantBank];
      cmdCol   <= slotBurst[grantBank] ? (slotCol[grantBank] & BURST_MASK)
                                       : slotCol[grantBank];
      cmdBurst <= slotBurst[grantBank];
      cmdTagR  <= slotTag[grantBank];
      if (strobe.issueAct)      cmdKindR <= CMD_ACT;
      else if (strobe.issuePre) cmdKindR <= CMD_PRE;
      else                      cmdKindR <= slotWrite[grantBank] ? CMD_WR : CMD_RD;
    end
  end

  assign cmdKind = cmdKindR;

  // Completion pipe, T_CL stages behind the command register
  logic             casV [T_CL];
  logic [TAG_W-1:0] casT [T_CL];
  logic             casW [T_CL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      casV[0] <= 1'b0;
      casT[0] <= '0;
      casW[0] <= 1'b0;
    end else begin
      casV[0] <= cmdValid && (cmdKindR inside {CMD_RD, CMD_WR});
      casT[0] <= cmdTagR;
      casW[0] <= (cmdKindR == CMD_WR);
    end
  end

  for (genvar k = 1; k < T_CL; k++) begin : g_cas
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        casV[k] <= 1'b0;
        casT[k] <= '0;
        casW[k] <= 1'b0;
      end else begin
        casV[k] <= casV[k-1];
        casT[k] <= casT[k-1];
        casW[k] <= casW[k-1];
      end
    end
  end

  assign doneValid = casV[T_CL-1];
  assign doneTag   = casT[T_CL-1];
  assign doneWrite = casW[T_CL-1];

  // R5
  col_open_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKindR inside {CMD_RD, CMD_WR}) |->
      (openValid[cmdBank] && openRow[cmdBank] == cmdRow));

  if (T_RCD >= 2) begin : g_rcd_chk
    // R2
    act_to_col_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid && cmdKindR == CMD_ACT) |=>
        !(cmdValid && cmdKindR inside {CMD_RD, CMD_WR} && cmdBank == $past(cmdBank)));
  end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TAG_W     = 4,
  parameter int MAX_OUT   = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_CL      = 3,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqBurst,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              cmdBurst,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic              doneWrite
);

  seqStrobe_t           strobe;
  logic [BANK_W-1:0]    grantBank;
  logic [NUM_BANKS-1:0] slotBusy, wantAct, wantPre, wantCol;

  dram_seq_ctrl #(
    .NUM_BANKS(NUM_BANKS), .MAX_OUT(MAX_OUT), .BANK_W(BANK_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .slotBusy(slotBusy), .wantAct(wantAct), .wantPre(wantPre), .wantCol(wantCol),
    .doneValid(doneValid), .reqReady(reqReady), .strobe(strobe), .grantBank(grantBank)
  );

  dram_seq_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL), .BURST_LEN(8), .BANK_W(BANK_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantBank(grantBank),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqTag(reqTag), .slotBusy(slotBusy), .wantAct(wantAct),
    .wantPre(wantPre), .wantCol(wantCol), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdBurst(cmdBurst),
    .doneValid(doneValid), .doneTag(doneTag), .doneWrite(doneWrite)
  );

endmodule

// File: tb/test_dram_cmd_seq.sv
module test_dram_cmd_seq;

  localparam int NB = 8, ROW_W = 8, COL_W = 6, TAG_W = 4;
  localparam int T_RCD = 2, T_RP = 2, T_CL = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [2:0] reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqReady, cmdValid, cmdBurst, doneValid, doneWrite;
  logic [1:0] cmdKind;
  logic [2:0] cmdBank;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;
  logic [TAG_W-1:0] doneTag;

  dram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .MAX_OUT(4), .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL)) i_dram_cmd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqBank(reqBank), .reqRow(reqRow),
    .reqCol(reqCol), .reqTag(reqTag), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .cmdBurst(cmdBurst),
    .doneValid(doneValid), .doneTag(doneTag), .doneWrite(doneWrite));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int accepts = 0, donesSeen = 0, cmdCount = 0, firstDone = -1;
  bit started = 0;
  logic pendV [NB], pendW [NB], pendB [NB], openV [NB];
  logic [ROW_W-1:0] pendRow [NB], openR [NB];
  logic [COL_W-1:0] pendCol [NB];
  logic [TAG_W-1:0] pendTag [NB];
  int actCyc [NB], preCyc [NB], colCyc [NB];
  logic [COL_W-1:0] colVal [NB];
  logic expV [16], expW [16];
  logic [TAG_W-1:0] expT [16];

  initial begin
    for (int i = 0; i < NB; i++) begin
      pendV[i] = 0; openV[i] = 0; pendW[i] = 0; pendB[i] = 0;
      pendRow[i] = '0; openR[i] = '0; pendCol[i] = '0; pendTag[i] = '0;
      actCyc[i] = -100; preCyc[i] = -100; colCyc[i] = -100; colVal[i] = '0;
    end
    for (int i = 0; i < 16; i++) begin expV[i] = 0; expW[i] = 0; expT[i] = '0; end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle monitor: command legality, readiness model, completion timing
  always begin
    @(negedge clk); #2;
    if (started) begin
      if (cmdValid) begin
        automatic int b = cmdBank;
        cmdCount++;
        if (cmdKind == 2'd0) begin
          chk(pendV[b] && openV[b] && openR[b] != pendRow[b], "R4 PRE legality", 0, 1);
          openV[b] = 0; preCyc[b] = cyc;
        end else if (cmdKind == 2'd1) begin
          chk(pendV[b] && !openV[b], "R2 ACT on closed bank", int'(openV[b]), 0);
          chk(cmdRow == pendRow[b], "R2 ACT row", cmdRow, pendRow[b]);
          chk(cyc - preCyc[b] >= T_RP, "R4 PRE-to-ACT gap", cyc - preCyc[b], T_RP);
          openV[b] = 1; openR[b] = cmdRow; actCyc[b] = cyc;
        end else begin
          automatic logic [COL_W-1:0] ec = pendB[b] ? (pendCol[b] & ~COL_W'(7)) : pendCol[b];
          chk(pendV[b] && openV[b] && openR[b] == pendRow[b], "R3 column to open row", 0, 1);
          chk(cyc - actCyc[b] >= T_RCD, "R2 ACT-to-column gap", cyc - actCyc[b], T_RCD);
          chk(cmdKind == (pendW[b] ? 2'd3 : 2'd2), "R5 column kind", cmdKind, pendW[b] ? 3 : 2);
          chk(cmdCol == ec, "R5 column field", cmdCol, ec);
          chk(cmdBurst == pendB[b], "R5 burst flag", cmdBurst, pendB[b]);
          chk(cmdRow == pendRow[b], "R5 column row", cmdRow, pendRow[b]);
          pendV[b] = 0; colCyc[b] = cyc; colVal[b] = cmdCol;
          expV[(cyc + T_CL) % 16] = 1;
          expT[(cyc + T_CL) % 16] = pendTag[b];
          expW[(cyc + T_CL) % 16] = pendW[b];
        end
      end
      // R7 R8 readiness model
      chk(reqReady == ((accepts - donesSeen) < 4 && !pendV[reqBank]),
          "R7/R8 ready", reqReady, ((accepts - donesSeen) < 4 && !pendV[reqBank]));
      // R6 completion timing and tag
      chk(doneValid == expV[cyc % 16], "R6 done timing", doneValid, expV[cyc % 16]);
      if (doneValid && expV[cyc % 16]) begin
        chk(doneTag == expT[cyc % 16], "R6 done tag", doneTag, expT[cyc % 16]);
        chk(doneWrite == expW[cyc % 16], "R6 done write", doneWrite, expW[cyc % 16]);
      end
      expV[cyc % 16] = 0;
      if (doneValid) begin
        donesSeen++;
        if (firstDone < 0) firstDone = cyc;
      end
    end
  end

  task automatic sendReq(input int b, input bit w, input bit bu, input int row,
                         input int col, input int tag, output int acc);
    bit r;
    reqValid = 1; reqBank = 3'(b); reqWrite = w; reqBurst = bu;
    reqRow = ROW_W'(row); reqCol = COL_W'(col); reqTag = TAG_W'(tag);
    forever begin
      #1; r = reqReady;
      @(posedge clk); @(negedge clk); #1;
      if (r) break;
    end
    acc = cyc; reqValid = 0; accepts++;
    pendV[b] = 1; pendW[b] = w; pendB[b] = bu;
    pendRow[b] = ROW_W'(row); pendCol[b] = COL_W'(col); pendTag[b] = TAG_W'(tag);
  endtask

  task automatic drain();
    while (accepts != donesSeen) begin @(negedge clk); #3; end
    repeat (2) @(negedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
  end

  initial begin
    int a, a2, c0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    started = 1;
    // R1 reset state
    chk(reqReady == 1, "R1 ready after reset", reqReady, 1);
    chk(cmdValid == 0, "R1 no command after reset", cmdValid, 0);
    chk(doneValid == 0, "R1 no completion after reset", doneValid, 0);

    // Sweep every bank: closed, hit (burst write), miss
    for (int b = 0; b < NB; b++) begin
      sendReq(b, 0, 0, b * 3 + 1, b * 5 + 1, b, a);
      drain();
      chk(actCyc[b] == a + 1, "R2 ACT one cycle after accept", actCyc[b], a + 1);
      chk(colCyc[b] == actCyc[b] + T_RCD, "R2 column after T_RCD", colCyc[b], actCyc[b] + T_RCD);

      c0 = cmdCount;
      sendReq(b, 1, 1, b * 3 + 1, b * 7 + 13, b + 8, a);
      drain();
      chk(colCyc[b] == a + 1, "R3 hit column one cycle after accept", colCyc[b], a + 1);
      chk(cmdCount - c0 == 1, "R3 hit issues only one command", cmdCount - c0, 1);
      chk(colVal[b] == (COL_W'(b * 7 + 13) & ~COL_W'(7)), "R5 burst aligned",
          colVal[b], COL_W'(b * 7 + 13) & ~COL_W'(7));

      c0 = cmdCount;
      sendReq(b, 0, 0, b * 3 + 2, b + 40, b, a);
      drain();
      chk(preCyc[b] == a + 1, "R4 PRE one cycle after accept", preCyc[b], a + 1);
      chk(actCyc[b] == preCyc[b] + T_RP, "R4 ACT after T_RP", actCyc[b], preCyc[b] + T_RP);
      chk(colCyc[b] == actCyc[b] + T_RCD, "R4 column after T_RCD", colCyc[b], actCyc[b] + T_RCD);
      chk(cmdCount - c0 == 3, "R4 miss issues three commands", cmdCount - c0, 3);
    end

    // R9: bank 1 hit collides with bank 3 ACT
    sendReq(3, 0, 0, 50, 4, 3, a);
    @(negedge clk); #1;
    sendReq(1, 1, 0, 5, 9, 1, a2);
    chk(a2 == a + 2, "R9 second accept", a2, a + 2);
    drain();
    chk(colCyc[1] == a + 3, "R9 lower bank column wins", colCyc[1], a + 3);
    chk(actCyc[3] == a + 4, "R9 higher bank ACT deferred", actCyc[3], a + 4);
    chk(colCyc[3] == a + 6, "R9 higher bank column", colCyc[3], a + 6);

    // R8: second request to a bank with a pending slot
    sendReq(5, 0, 0, 17, 2, 6, a);
    reqValid = 1; reqBank = 3'd5; reqRow = 8'd17;
    #1;
    chk(reqReady == 0, "R8 ready low for busy bank", reqReady, 0);
    sendReq(5, 0, 1, 17, 4, 7, a2);
    chk(a2 == a + 2, "R8 accept after column frees slot", a2, a + 2);
    drain();

    // R7 and R10: four outstanding, then stream while completions arrive
    firstDone = -1;
    for (int b = 0; b < 4; b++) begin
      sendReq(b, b % 2, 0, b + 100, b, b, a);
    end
    reqValid = 1; reqBank = 3'd4;
    #1;
    chk(reqReady == 0, "R7 ready low at four outstanding", reqReady, 0);
    sendReq(4, 0, 0, 90, 3, 4, a2);
    chk(a2 == firstDone + 2, "R7 ready returns after completion", a2, firstDone + 2);
    sendReq(6, 1, 1, 91, 63, 12, a);
    sendReq(7, 0, 0, 92, 1, 13, a);
    sendReq(2, 0, 0, 102, 5, 14, a);
    drain();
    chk(actCyc[1] < colCyc[0], "R10 bank 1 ACT before bank 0 column", actCyc[1], colCyc[0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule